// File: doc/BRIEF.md
# LDPC variable node processor

This block performs the per-cycle arithmetic of one degree-3 variable node in an iterative log-domain LDPC decoder. Each cycle in which its valid input is high it accepts one channel (intrinsic) message and three check-to-variable messages, all 5-bit sign-magnitude values. It forms the posterior log-likelihood ratio, derives a hard decision, and builds three variable-to-check messages. Each of these excludes the contribution of the edge it returns on and passes through the log-domain magnitude transform before it leaves.

Arithmetic is done in two's complement. Sign-magnitude is decoded on entry and re-encoded on exit. The datapath is split by one internal pipeline register into a summing half and a transforming half, and it sits in the decoder's memory read-modify-write loop. Every 6-bit output word carries the hard decision next to its message, so the surrounding memory stores both in one access. Memories and address generation belong to the surrounding decoder.

Top module: `ldpc_vn_top`

## Requirements
- R1: While reset is low, `out_valid`, `hard_dec` and every bit of `v2c_word` are 0 after the next rising clock edge.
- R2: `out_valid` is high exactly when `in_valid` was high at the rising edge two edges earlier, so results appear two clocks after their inputs are sampled.
- R3: Each message is sign-magnitude: bit 4 is the sign (1 = negative) and bits 3:0 the magnitude. The posterior is the intrinsic value plus all three incoming values. `hard_dec` is 0 when the posterior is strictly positive and 1 when it is zero or negative.
- R4: Outgoing message i comes from the exclusive sum, which is the posterior minus incoming value i. Its bit 4 is 1 when that sum is negative. Its bits 3:0 are round(f(0.5·m)/0.5), where m is the sum's magnitude and f(x)=ln((1+e^-x)/(1−e^-x)). For m = 0 it is 15. For m = 0..5 this gives 15, 3, 2, 1, 1, 0, and 0 above that.
- R5: Edge i occupies `v2c_word[6i+5:6i]`. Bit 6i+5 is the hard decision of the same result, and bits 6i+4:6i are outgoing message i.
- R6: An input with sign 1 and magnitude 0 (negative zero) is treated exactly as zero, on the intrinsic input and on every edge.
- R7: While `out_valid` is low, `hard_dec` and `v2c_word` keep their previous values.
- R8: Exclusive sums of magnitude above 15 are saturated to 15 before the transform, so they yield magnitude 0 with their sign kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input messages are valid this cycle |
| intr_msg | input | 5 | Intrinsic message, sign-magnitude |
| c2v_msg | input | 15 | Three check-to-variable messages, edge i at bits 5i+4:5i |
| out_valid | output | 1 | Output word and hard decision are valid |
| hard_dec | output | 1 | Hard decision of the posterior |
| v2c_word | output | 18 | Three words {hard decision, message}, edge i at bits 6i+5:6i |

## Verification
Every result, including the valid flag, the hard decision and all three words, is due two rising edges after its inputs are sampled, and it then holds until the next valid result. The bench drives inputs on the falling edge and compares all outputs at every falling edge against a reference state. That state advances through a two-step model that matches the summing register and the output register. The reference computes the transform with real-valued logarithms. Directed cases cover zero sums, negative zeros, saturation in both signs and idle gaps, and a long random run follows.

// File: rtl/ldpc_vn_pkg.sv
package ldpc_vn_pkg;

   // Magnitudes above this value all map to the same transform output.
   localparam int XF_SAT = 15;
   localparam int XF_IN_W = 4;

   // Log-domain transform f(x)=ln((1+e^-x)/(1-e^-x)).
   // Both the input and the output are quantised with a step of one half,
   // and the result is rounded to the nearest step.
   function automatic logic [XF_IN_W-1:0] vn_xform(input logic [XF_IN_W-1:0] m);
      logic [XF_IN_W-1:0] r;
      case (m)
         4'd0:    r = 4'd15;
         4'd1:    r = 4'd3;
         4'd2:    r = 4'd2;
         4'd3:    r = 4'd1;
         4'd4:    r = 4'd1;
         default: r = 4'd0;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/ldpc_vn_sm2tc.sv
module ldpc_vn_sm2tc #(
   parameter int MSG_W = 5,
   parameter int SUM_W = 7
) (
   input  logic [MSG_W-1:0]        sm_in,
   output logic signed [SUM_W-1:0] tc_out
);
   localparam int MAG_W = MSG_W - 1;

   logic [SUM_W-1:0] mag_ext;
   logic             is_neg;

   assign mag_ext = SUM_W'(sm_in[MAG_W-1:0]);
   // Negative zero collapses onto zero.
   assign is_neg  = sm_in[MSG_W-1] && (sm_in[MAG_W-1:0] != '0);
   assign tc_out  = is_neg ? -$signed(mag_ext) : $signed(mag_ext);
endmodule

// File: rtl/ldpc_vn_sum_half.sv
module ldpc_vn_sum_half #(
   parameter int MSG_W = 5,
   parameter int DEG   = 3,
   parameter int SUM_W = 7
) (
   input  logic [MSG_W-1:0]        intr_sm,
   input  logic [DEG*MSG_W-1:0]    edge_sm,
   output logic [DEG*SUM_W-1:0]    edge_tc,
   output logic signed [SUM_W-1:0] post_tc
);
   logic signed [SUM_W-1:0] intr_tc;

   ldpc_vn_sm2tc #(.MSG_W(MSG_W), .SUM_W(SUM_W)) u_cv_intr (
      .sm_in (intr_sm),
      .tc_out(intr_tc)
   );

   for (genvar e = 0; e < DEG; e++) begin : g_edge_cv
      ldpc_vn_sm2tc #(.MSG_W(MSG_W), .SUM_W(SUM_W)) u_cv (
         .sm_in (edge_sm[e*MSG_W +: MSG_W]),
         .tc_out(edge_tc[e*SUM_W +: SUM_W])
      );
   end

   always_comb begin
      logic signed [SUM_W-1:0] acc;
      acc = intr_tc;
      for (int e = 0; e < DEG; e++) begin
         acc = acc + $signed(edge_tc[e*SUM_W +: SUM_W]);
      end
      post_tc = acc;
   end
endmodule

// File: rtl/ldpc_vn_xf_half.sv
module ldpc_vn_xf_half #(
   parameter int MSG_W = 5,
   parameter int DEG   = 3,
   parameter int SUM_W = 7
) (
   input  logic signed [SUM_W-1:0] post_tc,
   input  logic [DEG*SUM_W-1:0]    edge_tc,
   output logic                    hd,
   output logic [DEG*MSG_W-1:0]    msg_sm
);
   import ldpc_vn_pkg::*;

   localparam int MAG_W = MSG_W - 1;

   // Strictly positive posterior gives 0, zero or negative gives 1.
   assign hd = ~((~post_tc[SUM_W-1]) & (|post_tc));

   for (genvar e = 0; e < DEG; e++) begin : g_edge_xf
      logic signed [SUM_W-1:0] excl;
      logic [SUM_W-1:0]        amag;
      logic [XF_IN_W-1:0]      sat;
      logic [XF_IN_W-1:0]      xf;

      assign excl = post_tc - $signed(edge_tc[e*SUM_W +: SUM_W]);
      assign amag = excl[SUM_W-1] ? $unsigned(-excl) : $unsigned(excl);
      assign sat  = (amag > SUM_W'(XF_SAT)) ? XF_IN_W'(XF_SAT) : amag[XF_IN_W-1:0];
      assign xf   = vn_xform(sat);
      assign msg_sm[e*MSG_W +: MSG_W] = {excl[SUM_W-1], MAG_W'(xf)};
   end
endmodule

// File: rtl/ldpc_vn_top.sv
module ldpc_vn_top #(
   parameter int MSG_W = 5,
   parameter int DEG   = 3,
   parameter int SUM_W = 7
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       in_valid,
   input  logic [MSG_W-1:0]           intr_msg,
   input  logic [DEG*MSG_W-1:0]       c2v_msg,
   output logic                       out_valid,
   output logic                       hard_dec,
   output logic [DEG*(MSG_W+1)-1:0]   v2c_word
);
   localparam int WORD_W = MSG_W + 1;
   localparam int MIN_SUM_W = MSG_W + $clog2(DEG + 1);

   if (MSG_W < 5) begin : g_bad_msg_w
      $error("ldpc_vn_top: MSG_W must be at least 5");
   end
   if (DEG < 2) begin : g_bad_deg
      $error("ldpc_vn_top: DEG must be at least 2");
   end
   if (SUM_W < MIN_SUM_W) begin : g_bad_sum_w
      $error("ldpc_vn_top: SUM_W too narrow for the posterior sum");
   end

   // First half: format conversion and summation.
   logic [DEG*SUM_W-1:0]    a_edge_tc;
   logic signed [SUM_W-1:0] a_post;

   ldpc_vn_sum_half #(.MSG_W(MSG_W), .DEG(DEG), .SUM_W(SUM_W)) u_sum (
      .intr_sm(intr_msg),
      .edge_sm(c2v_msg),
      .edge_tc(a_edge_tc),
      .post_tc(a_post)
   );

   // Internal pipeline register between the halves.
   logic                    mid_v;
   logic [DEG*SUM_W-1:0]    mid_edge_tc;
   logic signed [SUM_W-1:0] mid_post;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mid_v       <= 1'b0;
         mid_edge_tc <= '0;
         mid_post    <= '0;
      end else begin
         mid_v <= in_valid;
         if (in_valid) begin
            mid_edge_tc <= a_edge_tc;
            mid_post    <= a_post;
         end
      end
   end

   // Second half: exclusive sums, re-encoding and transform.
   logic                 b_hd;
   logic [DEG*MSG_W-1:0] b_msg;
   logic [DEG*WORD_W-1:0] b_word;

   ldpc_vn_xf_half #(.MSG_W(MSG_W), .DEG(DEG), .SUM_W(SUM_W)) u_xf (
      .post_tc(mid_post),
      .edge_tc(mid_edge_tc),
      .hd     (b_hd),
      .msg_sm (b_msg)
   );

   for (genvar e = 0; e < DEG; e++) begin : g_pack
      assign b_word[e*WORD_W +: WORD_W] = {b_hd, b_msg[e*MSG_W +: MSG_W]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         hard_dec  <= 1'b0;
         v2c_word  <= '0;
      end else begin
         out_valid <= mid_v;
         if (mid_v) begin
            hard_dec <= b_hd;
            v2c_word <= b_word;
         end
      end
   end
endmodule

// File: rtl/ldpc_vn_chk.sv
module ldpc_vn_chk #(
   parameter int MSG_W = 5,
   parameter int DEG   = 3
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     in_valid,
   input logic                     out_valid,
   input logic                     hard_dec,
   input logic [DEG*(MSG_W+1)-1:0] v2c_word
);
   localparam int WORD_W = MSG_W + 1;
   localparam int MAG_W  = MSG_W - 1;

   logic [1:0] age;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          age <= 2'd0;
      else if (age != 2'd2) age <= 2'(age + 2'd1);
   end

   AST_RESET_CLEAR: assert property (@(posedge clk)
      !rst_n |=> (!out_valid && !hard_dec && (v2c_word == '0))); // R1

   AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd2) |-> (out_valid == $past(in_valid, 2))); // R2

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      ((age != 2'd0) && !out_valid) |-> ($stable(v2c_word) && $stable(hard_dec))); // R7

   for (genvar e = 0; e < DEG; e++) begin : g_edge
      logic [MAG_W-1:0] mag;
      logic             sgn;
      logic             hdb;
      assign mag = v2c_word[e*WORD_W +: MAG_W];
      assign sgn = v2c_word[e*WORD_W + MAG_W];
      assign hdb = v2c_word[e*WORD_W + MSG_W];

      AST_BUNDLED_HD: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid |-> (hdb == hard_dec)); // R5

      AST_MAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid |-> ((mag == MAG_W'(0)) || (mag == MAG_W'(1)) || (mag == MAG_W'(2)) ||
                        (mag == MAG_W'(3)) || (mag == MAG_W'(15)))); // R4

      AST_ZERO_SUM_POS: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && (mag == MAG_W'(15))) |-> !sgn); // R4
   end
endmodule

bind ldpc_vn_top ldpc_vn_chk #(.MSG_W(MSG_W), .DEG(DEG)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .out_valid(out_valid),
   .hard_dec (hard_dec),
   .v2c_word (v2c_word)
);

// File: tb/ldpc_vn_top_test.sv
module ldpc_vn_top_test;
   localparam int DEG = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [4:0]  intr_msg = '0;
   logic [14:0] c2v_msg = '0;
   logic        out_valid;
   logic        hard_dec;
   logic [17:0] v2c_word;

   ldpc_vn_top uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .intr_msg(intr_msg),
      .c2v_msg(c2v_msg), .out_valid(out_valid), .hard_dec(hard_dec), .v2c_word(v2c_word)
   );

   always #5 clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   // Reference state: stage after the first register, then the outputs.
   bit          m_v = 0;
   logic [4:0]  m_intr = '0;
   logic [14:0] m_c = '0;
   bit          e_v = 0;
   bit          e_hd = 0;
   logic [17:0] e_w = '0;
   string       e_tag [DEG];

   task automatic chk(string tag, bit ok, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int smv(logic [4:0] v);
      return v[4] ? -int'(v[3:0]) : int'(v[3:0]);
   endfunction

   function automatic int xf(int m);
      real x, f;
      int q;
      if (m == 0) return 15;
      x = 0.5 * m;
      f = $ln((1.0 + $exp(-x)) / (1.0 - $exp(-x)));
      q = $rtoi(f * 2.0 + 0.5);
      if (q > 15) q = 15;
      return q;
   endfunction

   task automatic compute(logic [4:0] iv, logic [14:0] cv);
      int post, ex, a, q;
      bit negz;
      negz = (iv == 5'b10000);
      post = smv(iv);
      for (int i = 0; i < DEG; i++) begin
         post += smv(cv[i*5 +: 5]);
         if (cv[i*5 +: 5] == 5'b10000) negz = 1;
      end
      e_hd = (post > 0) ? 1'b0 : 1'b1;
      for (int i = 0; i < DEG; i++) begin
         ex = post - smv(cv[i*5 +: 5]);
         a = (ex < 0) ? -ex : ex;
         e_tag[i] = negz ? "R6" : ((a > 15) ? "R8" : "R4");
         if (a > 15) a = 15;
         q = xf(a);
         e_w[i*6 +: 6] = {e_hd, (ex < 0), 4'(q)};
      end
   endtask

   task automatic check_outputs();
      if (!rst_n) begin
         chk("R1", !out_valid && !hard_dec && (v2c_word == '0), int'(v2c_word), 0);
      end else begin
         chk("R2", out_valid == e_v, int'(out_valid), int'(e_v));
         if (e_v) begin
            chk("R3", hard_dec == e_hd, int'(hard_dec), int'(e_hd));
            for (int i = 0; i < DEG; i++) begin
               chk("R5", v2c_word[i*6+5] == e_hd, int'(v2c_word[i*6+5]), int'(e_hd));
               chk(e_tag[i], v2c_word[i*6 +: 5] == e_w[i*6 +: 5],
                   int'(v2c_word[i*6 +: 5]), int'(e_w[i*6 +: 5]));
            end
         end else begin
            chk("R7", (hard_dec == e_hd) && (v2c_word == e_w), int'(v2c_word), int'(e_w));
         end
      end
   endtask

   task automatic step(bit r, bit v, logic [4:0] iv, logic [14:0] cv);
      @(negedge clk);
      check_outputs();
      if (!r) begin
         m_v = 0; m_intr = '0; m_c = '0;
         e_v = 0; e_hd = 0; e_w = '0;
      end else begin
         e_v = m_v;
         if (m_v) compute(m_intr, m_c);
         m_v = v; m_intr = iv; m_c = cv;
      end
      rst_n = r;
      in_valid = v;
      intr_msg = iv;
      c2v_msg = cv;
   endtask

   initial begin
      repeat (3) step(0, 0, '0, '0);
      step(1, 0, '0, '0);
      // R3/R4: all-zero sums give hard decision 1 and magnitude 15 positive
      step(1, 1, 5'b00000, {5'b00000, 5'b00000, 5'b00000});
      // R6: negative zero everywhere behaves as zero
      step(1, 1, 5'b10000, {5'b10000, 5'b10000, 5'b10000});
      // R8: large positive sums saturate
      step(1, 1, 5'b01111, {5'b01111, 5'b01111, 5'b01111});
      // R8: large negative sums saturate with sign kept
      step(1, 1, 5'b11111, {5'b11111, 5'b11111, 5'b11111});
      // R7: idle gap holds outputs
      step(1, 0, 5'b00101, {5'b00011, 5'b10010, 5'b00001});
      step(1, 0, 5'b00110, {5'b00011, 5'b10010, 5'b00001});
      // R4: small mixed values
      step(1, 1, 5'b00001, {5'b00000, 5'b10001, 5'b00001});
      // R3: posterior exactly zero
      step(1, 1, 5'b10001, {5'b00000, 5'b00000, 5'b00001});
      step(1, 1, 5'b00011, {5'b00100, 5'b10000, 5'b10010});
      step(1, 1, 5'b00010, {5'b10011, 5'b00001, 5'b00010});
      repeat (3) step(1, 0, '0, '0);
      for (int k = 0; k < 400; k++) begin
         step(1, ($urandom % 4) != 0, 5'($urandom), 15'($urandom));
      end
      // R1: reset in the middle of traffic
      step(1, 1, 5'b00111, {5'b00101, 5'b00110, 5'b01000});
      step(0, 1, 5'b00111, {5'b00101, 5'b00110, 5'b01000});
      step(0, 0, '0, '0);
      step(1, 1, 5'b11000, {5'b00010, 5'b00011, 5'b10001});
      repeat (4) step(1, 0, '0, '0);
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #2000000;
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL R2 watchdog actual=%0d expected=%0d", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule